// File: doc/BRIEF.md
# Watchdog Timer with Shared Rate Scaler

This block is a watchdog that advances on a tick enable that comes from its own free-running oscillator. That tick keeps arriving while the core clock is halted for low-power sleep. An 8-bit base counter overflows once every 256 watchdog ticks. A single 8-bit rate scaler is shared between two users, and one assignment input decides which user owns it:

- **Watchdog owns the scaler.** The scaler divides the base-counter overflow and produces the time-out. The general-purpose timer tick passes through at 1:1.
- **Timer owns the scaler.** The scaler divides the timer source tick. The watchdog times out directly on each base overflow.

A 3-bit rate select chooses one of eight scaler taps.

The response to a time-out depends on the sleep input. While the core is awake, a time-out produces a one-cycle reset request. While the core sleeps, it produces a one-cycle wake-up request instead. Every time-out drives an active-low time-out status flag low. A clear strobe restarts the count and sets the flag high again. A sleep-entry strobe restarts the count but leaves the flag alone. A static enable, when low, keeps the watchdog from ever timing out. All interfaces are plain control and status pins; there is no data stream and so no handshake.

Top module: `wdog_shared_scaler`

## Requirements
- R1: With the scaler assigned to the watchdog (`scl_to_wd_i`=1) and rate select k (0..7), a time-out occurs on exactly the 256·2^k-th watchdog tick after a clear strobe, whatever the spacing between ticks.
- R2: A time-out while `asleep_i`=0 raises `rst_req_o` for exactly one cycle, in the cycle after the tick that timed out, and `wake_req_o` stays low.
- R3: A time-out while `asleep_i`=1 raises `wake_req_o` for one cycle, and `rst_req_o` stays low.
- R4: Every time-out drives `to_n_o` low, and it stays low until a clear strobe.
- R5: While `wd_en_i`=0 no time-out occurs and the base counter is held at zero. After enabling, 256 ticks (times the scaler ratio) are needed before a time-out.
- R6: A sleep-entry strobe restarts the base count, and also the scaler count when the scaler is assigned to the watchdog, exactly as a clear strobe does.
- R7: A clear strobe sets `to_n_o` high in the following cycle.
- R8: With the scaler assigned to the timer (`scl_to_wd_i`=0) and rate select k, `tmr_tick_o` pulses once per 2^(k+1) `tmr_src_tick_i` ticks.
- R9: With the scaler assigned to the timer, the watchdog times out every 256 ticks regardless of rate select, and clear or sleep strobes leave the scaler phase untouched.
- R10: With the scaler assigned to the watchdog, `tmr_tick_o` equals `tmr_src_tick_i` (1:1).
- R11: After power-on reset, `rst_req_o` and `wake_req_o` are low and `to_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running block clock |
| rst_n | input | 1 | Active-low power-on reset |
| wd_tick_i | input | 1 | Tick enable from the watchdog's own oscillator |
| wd_en_i | input | 1 | Static watchdog enable |
| scl_to_wd_i | input | 1 | Scaler assignment: 1 = watchdog, 0 = timer |
| rate_sel_i | input | 3 | Scaler tap select |
| tmr_src_tick_i | input | 1 | Source tick of the general-purpose timer |
| clear_stb_i | input | 1 | Watchdog clear strobe |
| sleep_stb_i | input | 1 | Sleep-entry strobe |
| asleep_i | input | 1 | Core is in sleep |
| rst_req_o | output | 1 | One-cycle reset request |
| wake_req_o | output | 1 | One-cycle wake-up request |
| to_n_o | output | 1 | Active-low time-out flag |
| tmr_tick_o | output | 1 | Tick delivered to the general-purpose timer |

## Verification
The hardest case to reach is the longest time-out: the scaler at 1:128 with the watchdog as owner. Only 32768 consecutive ticks, with no clear, reach it. The scaler's phase must also be known at the start, and the only way to know it is a clear strobe issued while the watchdog owns the scaler. The bench therefore issues a clear after every change of rate select. It then counts ticks one at a time until a request appears, sweeping all eight taps in both assignments. In timer mode, the bench measures the interval between two steady-state output pulses, which avoids depending on the unknown starting phase. It also checks that a clear issued mid-interval leaves the next pulse at its original position.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned BASE_W_DEF = 8;
  localparam int unsigned SCL_W_DEF  = 8;
  localparam int unsigned SEL_W_DEF  = 3;

  // Width of a tap exponent able to hold 0..scl_w
  function automatic int unsigned exp_width(input int unsigned scl_w);
    return $clog2(scl_w + 1);
  endfunction
endpackage

// File: rtl/wdog_base_ctr.sv
module wdog_base_ctr #(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic tick_i,
  input  logic restart_i,
  output logic ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart_i || !en_i) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end

  // a restart in the same cycle wins over the wrap
  assign ovf_o = en_i && tick_i && !restart_i && (&cnt_q);
endmodule

// File: rtl/wdog_scaler.sv
module wdog_scaler #(
  parameter int unsigned W     = 8,
  parameter int unsigned EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             in_tick_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             out_tick_o
);
  logic [W-1:0] cnt_q;
  logic [W:0]   tap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (in_tick_i)  cnt_q <= cnt_q + 1'b1;
  end

  // tap k fires when the low k bits are all ones (ratio 2^k)
  assign tap_hit[0] = 1'b1;
  for (genvar k = 1; k <= W; k++) begin : g_tap
    assign tap_hit[k] = &cnt_q[k-1:0];
  end

  logic sel_hit;
  always_comb begin
    sel_hit = 1'b0;
    for (int k = 0; k <= W; k++) begin
      if (exp_i == EXP_W'(k)) sel_hit = tap_hit[k];
    end
  end

  assign out_tick_o = in_tick_i && !clr_i && sel_hit;
endmodule

// File: rtl/wdog_event.sv
module wdog_event (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_i,
  input  logic asleep_i,
  input  logic clear_i,
  output logic rst_req_o,
  output logic wake_req_o,
  output logic to_n_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req_o  <= 1'b0;
      wake_req_o <= 1'b0;
      to_n_o     <= 1'b1;
    end else begin
      rst_req_o  <= timeout_i && !asleep_i;
      wake_req_o <= timeout_i && asleep_i;
      if (timeout_i)    to_n_o <= 1'b0;
      else if (clear_i) to_n_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_shared_scaler.sv
module wdog_shared_scaler
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_W = BASE_W_DEF,
  parameter int unsigned SCL_W  = SCL_W_DEF,
  parameter int unsigned SEL_W  = SEL_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_tick_i,
  input  logic             wd_en_i,
  input  logic             scl_to_wd_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  input  logic             tmr_src_tick_i,
  input  logic             clear_stb_i,
  input  logic             sleep_stb_i,
  input  logic             asleep_i,
  output logic             rst_req_o,
  output logic             wake_req_o,
  output logic             to_n_o,
  output logic             tmr_tick_o
);
  localparam int unsigned EXP_W = exp_width(SCL_W);

  logic             restart;
  logic             base_ovf;
  logic             scl_clr;
  logic             scl_in;
  logic             scl_out;
  logic             timeout;
  logic [EXP_W-1:0] tap_exp;

  assign restart = clear_stb_i || sleep_stb_i;
  assign scl_clr = restart && scl_to_wd_i;
  assign scl_in  = scl_to_wd_i ? base_ovf : tmr_src_tick_i;
  // watchdog side starts at 1:1, timer side at 1:2
  assign tap_exp = scl_to_wd_i ? EXP_W'(rate_sel_i) : EXP_W'(rate_sel_i) + 1'b1;

  wdog_base_ctr #(.W(BASE_W)) base_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (wd_en_i),
    .tick_i    (wd_tick_i),
    .restart_i (restart),
    .ovf_o     (base_ovf)
  );

  wdog_scaler #(.W(SCL_W), .EXP_W(EXP_W)) scaler_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (scl_clr),
    .in_tick_i  (scl_in),
    .exp_i      (tap_exp),
    .out_tick_o (scl_out)
  );

  assign timeout    = scl_to_wd_i ? scl_out : base_ovf;
  assign tmr_tick_o = scl_to_wd_i ? tmr_src_tick_i : scl_out;

  wdog_event event_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .timeout_i  (timeout),
    .asleep_i   (asleep_i),
    .clear_i    (clear_stb_i),
    .rst_req_o  (rst_req_o),
    .wake_req_o (wake_req_o),
    .to_n_o     (to_n_o)
  );
endmodule

// File: rtl/wdog_shared_scaler_chk.sv
module wdog_shared_scaler_chk (
  input logic clk,
  input logic rst_n,
  input logic wd_en_i,
  input logic clear_stb_i,
  input logic asleep_i,
  input logic rst_req_o,
  input logic wake_req_o,
  input logic to_n_o
);
  p_req_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rst_req_o && wake_req_o));

  p_reset_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_wake_from_sleep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req_o |-> $past(asleep_i));

  p_flag_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_o || wake_req_o) |-> !to_n_o);

  p_clear_sets_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_stb_i |=> to_n_o);

  p_disabled_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en_i |=> !(rst_req_o || wake_req_o));
endmodule

bind wdog_shared_scaler wdog_shared_scaler_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wd_en_i     (wd_en_i),
  .clear_stb_i (clear_stb_i),
  .asleep_i    (asleep_i),
  .rst_req_o   (rst_req_o),
  .wake_req_o  (wake_req_o),
  .to_n_o      (to_n_o)
);

// File: tb/wdog_shared_scaler_tb.sv
module wdog_shared_scaler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wd_tick = 1'b0, wd_en = 1'b1, to_wd = 1'b1;
  logic [2:0] sel = 3'd0;
  logic       tsrc = 1'b0, clr = 1'b0, slp = 1'b0, asleep = 1'b0;
  logic       rst_req, wake_req, to_n, ttick;
  int         checks = 0, errors = 0;

  always #2 clk = ~clk;

  wdog_shared_scaler dut_i (
    .clk(clk), .rst_n(rst_n), .wd_tick_i(wd_tick), .wd_en_i(wd_en),
    .scl_to_wd_i(to_wd), .rate_sel_i(sel), .tmr_src_tick_i(tsrc),
    .clear_stb_i(clr), .sleep_stb_i(slp), .asleep_i(asleep),
    .rst_req_o(rst_req), .wake_req_o(wake_req), .to_n_o(to_n), .tmr_tick_o(ttick)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe_clear();
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic strobe_sleep();
    @(negedge clk) slp = 1'b1;
    @(negedge clk) slp = 1'b0;
  endtask

  // drive watchdog ticks until a request appears or limit is reached
  task automatic run_ticks(input int gap, input int limit,
                           output int n, output bit r, output bit w);
    n = 0; r = 0; w = 0;
    while (n < limit) begin
      @(negedge clk) wd_tick = 1'b1;
      @(posedge clk); #1;
      wd_tick = 1'b0;
      n++;
      r = rst_req; w = wake_req;
      if (r || w) break;
      repeat (gap) @(negedge clk);
    end
  endtask

  // cycles between the 2nd and 3rd tmr_tick_o pulses with tsrc held high
  task automatic tmr_interval(output int iv);
    int seen = 0, last = 0;
    iv = -1;
    for (int c = 0; c < 2000; c++) begin
      @(negedge clk); #1;
      if (ttick) begin
        seen++;
        if (seen == 3) begin iv = c - last; break; end
        last = c;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n; bit r, w; int iv;
    repeat (3) @(negedge clk);
    #1;
    chk(rst_req == 0 && wake_req == 0, "R11 reqs after reset", rst_req + wake_req, 0);
    chk(to_n == 1, "R11 to_n after reset", to_n, 1);
    rst_n = 1'b1;

    // R1 / R2 / R4: sweep all taps with watchdog ownership
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k);
      strobe_clear();
      run_ticks(0, (256 << k) + 4, n, r, w);
      chk(n == (256 << k), "R1 ticks to time-out", n, 256 << k);
      chk(r && !w, "R2 reset request while awake", {r, w}, 2);
      chk(to_n == 0, "R4 to_n low after time-out", to_n, 0);
      @(posedge clk); #1;
      chk(rst_req == 0, "R2 reset request one cycle", rst_req, 0);
      chk(to_n == 0, "R4 to_n holds low", to_n, 0);
    end
    strobe_clear(); #1;
    chk(to_n == 1, "R7 clear raises to_n", to_n, 1);

    // R1 with sparse ticks
    sel = 3'd0;
    strobe_clear();
    run_ticks(2, 300, n, r, w);
    chk(n == 256 && r, "R1 sparse ticks", n, 256);

    // R3 / R6: sleep entry restarts, time-out wakes
    sel = 3'd1;
    strobe_clear();
    run_ticks(0, 100, n, r, w);
    asleep = 1'b1;
    strobe_sleep();
    run_ticks(0, 600, n, r, w);
    chk(n == 512, "R6 sleep strobe restarts count", n, 512);
    chk(w && !r, "R3 wake request while asleep", {r, w}, 1);
    chk(to_n == 0, "R4 to_n low after wake", to_n, 0);
    asleep = 1'b0;
    strobe_clear();

    // R5: disabled never times out, counter held at zero
    sel = 3'd0;
    strobe_clear();
    run_ticks(0, 100, n, r, w);
    wd_en = 1'b0;
    run_ticks(0, 700, n, r, w);
    chk(!r && !w && n == 700, "R5 disabled no time-out", n, 700);
    wd_en = 1'b1;
    run_ticks(0, 300, n, r, w);
    chk(n == 256 && r, "R5 count restarts from zero", n, 256);

    // R10: pass-through when watchdog owns the scaler
    for (int c = 0; c < 6; c++) begin
      @(negedge clk) tsrc = c[0]; #1;
      chk(ttick == tsrc, "R10 timer tick pass-through", ttick, tsrc);
    end

    // R9: timer ownership, watchdog at 1:256 for any select
    to_wd = 1'b0;
    tsrc = 1'b0;
    sel = 3'd5;
    strobe_clear();
    run_ticks(0, 300, n, r, w);
    chk(n == 256 && r, "R9 direct time-out", n, 256);
    strobe_clear();

    // R8: timer-side ratios
    tsrc = 1'b1;
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k);
      tmr_interval(iv);
      chk(iv == (2 << k), "R8 timer interval", iv, 2 << k);
    end

    // R9: clear mid-interval leaves timer phase alone
    sel = 3'd3;
    begin
      int c = 0;
      do begin @(negedge clk); #1; end while (!ttick);
      @(negedge clk) clr = 1'b1; #1; c = 1;
      @(negedge clk) clr = 1'b0; #1; c = 2;
      while (!ttick && c < 100) begin @(negedge clk); #1; c++; end
      chk(c == 16, "R9 clear keeps timer phase", c, 16);
    end

    tsrc = 1'b0;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule